// File: doc/BRIEF.md
# Conversion Trigger Delay Timer Bank

This block paces conversion requests for an analog-to-digital converter through a bank of programmable countdown channels. A prescaler divides the system clock down to a slow timebase tick (nominally 2 kHz). Each channel counts its programmed delay in those ticks. When a channel runs out, it sends a one-cycle request to every conversion slot named in its slot mask. In the same cycle it restarts every channel named in its chain mask, and it may name itself there.

A per-channel round counter lets a channel repeat a number of rounds with no software involvement. The channel then stops on its own, so a downstream result interrupt can be raised once per batch. For example, a delay of 200 ticks with five rounds yields one batch every 500 ms at a 2 kHz tick. Software programs each channel through a one-word register, written plainly or through set and clear aliases. Setting the run bit arms the channel and clearing it stops the channel.

Top module: `dly_trig_bank`

## Requirements
- R1: After reset every channel register reads zero, and `conv_req` and `dly_expire` are low.
- R2: `base_tick` is high for one cycle out of every `TICK_DIV` cycles.
- R3: The channel register holds the slot mask in bits 31:24, the run bit in bit 20, the chain mask in bits 19:16, the round count in bits 15:11 and the delay in bits 10:0. Bits 23:21 read zero. `wr_addr[1:0]` selects the channel and `rd_addr` selects the channel shown on `rd_data`.
- R4: A write with alias 0 (plain) or alias 1 (set) that carries the run bit loads the channel's counter with the delay. The channel then expires on the delay-th following tick, or on the first tick when the delay is 0 or 1. `dly_expire[i]` pulses for one cycle in the cycle after that tick.
- R5: In the same cycle as `dly_expire`, `conv_req` pulses the OR of the slot masks of all channels that expired together.
- R6: An expiring channel sets the run bit and reloads the counter of every channel whose bit is set in its chain mask, itself included.
- R7: On expiry a non-zero round count is decremented. If the count is then zero, the run bit clears unless a chain restart reaches the channel in the same cycle. Otherwise the counter reloads and the channel keeps running. A count of N ≥ 1 thus gives N expiries and a count of 0 gives one.
- R8: A channel whose run bit has been cleared, through alias 2 (clear) or an all-zero plain write, produces no further expiries.
- R9: A software write to a channel in a given cycle decides that channel's register for that cycle, overriding the round decrement, the self-clear and any chain restart. An expiry in that cycle is still reported.
- R10: A write with alias 3 (`wr_addr[3:2]` = 3) has no effect on any register.
- R11: With a delay of 200 and a round count of 5, a channel expires exactly five times, 200 ticks apart, and then stops with a round count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 4 | [3:2] alias (0 plain, 1 set, 2 clear, 3 none), [1:0] channel |
| wr_data | input | 32 | Write data in the channel register layout |
| rd_addr | input | 2 | Channel shown on rd_data |
| rd_data | output | 32 | Current register word of the selected channel |
| base_tick | output | 1 | Timebase tick, one cycle wide |
| conv_req | output | 8 | One-cycle conversion requests per slot |
| dly_expire | output | 4 | One-cycle expiry pulse per channel |

## Verification
The assertions check several rules on every cycle. A channel only expires on a tick. A request pulse always follows an expiry. The last round clears the run bit, and a middle round decrements the count and keeps the channel running. A chain restart arms its target, an idle channel stays idle, and a software write leaves the counter to software. The bench's scenarios are needed for the end-to-end timing: the number of ticks up to an expiry, the round spacing over a full batch, and two channels started by a shared chain that fire together with merged slot requests. The same holds for the ordering rule, where a write lands exactly on an expiring tick and keeps the channel armed. Random traffic through all four aliases is compared against a cycle model in the bench.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int REG_W     = 32;
  localparam int SLOT_W    = 8;
  localparam int CHAIN_W   = 4;
  localparam int LOOP_W    = 5;
  localparam int DLY_W     = 11;
  localparam int SLOT_LSB  = 24;
  localparam int KICK_POS  = 20;
  localparam int CHAIN_LSB = 16;
  localparam int LOOP_LSB  = 11;
  localparam int DLY_LSB   = 0;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } wr_op_e;

  typedef struct packed {
    logic [SLOT_W-1:0]  slots;
    logic               kick;
    logic [CHAIN_W-1:0] chain;
    logic [LOOP_W-1:0]  loops;
    logic [DLY_W-1:0]   delay;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    chan_cfg_t c;
    c.slots = w[SLOT_LSB +: SLOT_W];
    c.kick  = w[KICK_POS];
    c.chain = w[CHAIN_LSB +: CHAIN_W];
    c.loops = w[LOOP_LSB +: LOOP_W];
    c.delay = w[DLY_LSB +: DLY_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input chan_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SLOT_LSB +: SLOT_W]   = c.slots;
    w[KICK_POS]             = c.kick;
    w[CHAIN_LSB +: CHAIN_W] = c.chain;
    w[LOOP_LSB +: LOOP_W]   = c.loops;
    w[DLY_LSB +: DLY_W]     = c.delay;
    return w;
  endfunction

  // Register update for the three active aliases.
  function automatic chan_cfg_t cfg_apply(input chan_cfg_t old,
                                          input logic [REG_W-1:0] w,
                                          input wr_op_e op);
    case (op)
      OP_LOAD: return cfg_from_word(w);
      OP_SET:  return cfg_from_word(cfg_to_word(old) | w);
      OP_CLR:  return cfg_from_word(cfg_to_word(old) & ~w);
      default: return old;
    endcase
  endfunction

  // True when the write (re)arms the channel and so reloads its counter.
  function automatic logic kick_written(input wr_op_e op, input logic [REG_W-1:0] w);
    return ((op == OP_LOAD) || (op == OP_SET)) && w[KICK_POS];
  endfunction

  // The counter expires on the tick that finds it at one or zero.
  function automatic logic count_done(input logic [DLY_W-1:0] c);
    return c <= DLY_W'(1);
  endfunction

  function automatic logic [LOOP_W-1:0] loop_after(input logic [LOOP_W-1:0] l);
    return (l == '0) ? '0 : l - LOOP_W'(1);
  endfunction

endpackage

// File: rtl/dtm_tick.sv
module dtm_tick #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PRE_W = $clog2(TICK_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                       pre_q <= pre_q + PRE_W'(1);
      end

      assign tick_o = (pre_q == PRE_LAST);

      // R2: a tick is never followed directly by another tick.
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dtm_chan.sv
module dtm_chan
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sw_wr_i,
  input  wr_op_e           sw_op_i,
  input  logic [REG_W-1:0] sw_data_i,
  input  logic             restart_i,
  output chan_cfg_t        cfg_o,
  output logic             expire_o
);
  chan_cfg_t        cfg_q, cfg_n;
  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             running;
  logic [LOOP_W-1:0] loops_left;

  assign running    = cfg_q.kick;
  assign expire_o   = tick_i && running && count_done(cnt_q);
  assign loops_left = loop_after(cfg_q.loops);

  always_comb begin
    cfg_n = cfg_q;
    cnt_n = cnt_q;
    if (sw_wr_i) begin
      // R9: software owns the register in its write cycle.
      cfg_n = cfg_apply(cfg_q, sw_data_i, sw_op_i);
      if (kick_written(sw_op_i, sw_data_i)) cnt_n = cfg_n.delay;
    end else begin
      if (expire_o) begin
        cfg_n.loops = loops_left;
        cnt_n       = cfg_q.delay;
        if (loops_left == '0) cfg_n.kick = 1'b0;
      end else if (tick_i && running) begin
        cnt_n = cnt_q - DLY_W'(1);
      end
      if (restart_i) begin
        cfg_n.kick = 1'b1;
        cnt_n      = cfg_q.delay;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      cnt_q <= cnt_n;
    end
  end

  assign cfg_o = cfg_q;

  // R7: the final round stops the channel unless it is restarted.
  p_last_round_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && (cfg_q.loops <= LOOP_W'(1)) && !restart_i && !sw_wr_i) |=> !cfg_q.kick);

  // R7: a middle round counts down and keeps running.
  p_round_counts_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && (cfg_q.loops > LOOP_W'(1)) && !sw_wr_i)
      |=> (cfg_q.kick && (cfg_q.loops == $past(cfg_q.loops) - LOOP_W'(1))));

  // R6: a chain restart arms the channel with a fresh count.
  p_restart_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !sw_wr_i) |=> (cfg_q.kick && (cnt_q == $past(cfg_q.delay))));

  // R8: a stopped channel stays stopped and its count frozen.
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.kick && !restart_i && !sw_wr_i) |=> (!cfg_q.kick && $stable(cnt_q)));

  // R9: a write that does not arm leaves the counter untouched by hardware.
  p_sw_owns_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !kick_written(sw_op_i, sw_data_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/dly_trig_bank.sv
module dly_trig_bank
  import dtm_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int N_CH     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_valid,
  input  logic [((N_CH > 1) ? $clog2(N_CH) : 1) + 1:0] wr_addr,
  input  logic [31:0]                         wr_data,
  input  logic [((N_CH > 1) ? $clog2(N_CH) : 1) - 1:0] rd_addr,
  output logic [31:0]                         rd_data,
  output logic                                base_tick,
  output logic [SLOT_W-1:0]                   conv_req,
  output logic [N_CH-1:0]                     dly_expire
);
  localparam int CH_IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int ADDR_W   = CH_IDX_W + 2;

  logic                tick;
  wr_op_e              wr_op;
  logic [CH_IDX_W-1:0] wr_ch;
  logic [N_CH-1:0]     wr_hit;
  logic [N_CH-1:0]     expire_vec;
  logic [N_CH-1:0]     restart_vec;
  logic [SLOT_W-1:0]   req_any;
  chan_cfg_t           cfg_vec [N_CH];
  logic [SLOT_W-1:0]   conv_req_q;
  logic [N_CH-1:0]     dly_expire_q;

  dtm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  assign wr_op = wr_op_e'(wr_addr[ADDR_W-1 -: 2]);
  assign wr_ch = wr_addr[CH_IDX_W-1:0];

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign wr_hit[g] = wr_valid && (wr_ch == CH_IDX_W'(g)) && (wr_op != OP_NONE);
      dtm_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .sw_wr_i   (wr_hit[g]),
        .sw_op_i   (wr_op),
        .sw_data_i (wr_data),
        .restart_i (restart_vec[g]),
        .cfg_o     (cfg_vec[g]),
        .expire_o  (expire_vec[g])
      );
    end
  endgenerate

  // Merge slot requests and fan out chain restarts of all expiring channels.
  always_comb begin
    req_any     = '0;
    restart_vec = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (expire_vec[i]) begin
        req_any = req_any | cfg_vec[i].slots;
        for (int j = 0; j < N_CH; j++) begin
          if (cfg_vec[i].chain[j]) restart_vec[j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_req_q   <= '0;
      dly_expire_q <= '0;
    end else begin
      conv_req_q   <= req_any;
      dly_expire_q <= expire_vec;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_addr == CH_IDX_W'(i)) rd_data = cfg_to_word(cfg_vec[i]);
    end
  end

  assign base_tick  = tick;
  assign conv_req   = conv_req_q;
  assign dly_expire = dly_expire_q;

  // R4: channels only expire on a timebase tick.
  p_expire_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire_vec) |-> tick);

  // R5: a request pulse always follows an expiry.
  p_req_needs_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|conv_req_q) |-> $past(|expire_vec));
endmodule

// File: tb/tb_dly_trig_bank.sv
`timescale 1ns/100ps
module tb_dly_trig_bank;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        base_tick;
  logic [7:0]  conv_req;
  logic [3:0]  dly_expire;

  always #2 clk = ~clk;

  dly_trig_bank #(.TICK_DIV(DIV), .N_CH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .base_tick(base_tick), .conv_req(conv_req), .dly_expire(dly_expire));

  int checks = 0;
  int fails  = 0;
  localparam logic [31:0] WMASK = 32'hFF1F_FFFF;

  logic [31:0] m_cfg [4];
  int          m_cnt [4];
  logic [7:0]  exp_req;
  logic [3:0]  exp_exp;
  logic [7:0]  obs_req;
  logic [3:0]  obs_exp;
  logic        cur_tick;
  int          rd_sel = 0;
  int          gap = 0;
  bit          seen_tick = 0;
  int          cyc = 0;

  function automatic logic [31:0] mk(int s, int k, int c, int l, int d);
    return {s[7:0], 3'b000, k[0], c[3:0], l[4:0], d[10:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Reference behaviour, stepped once per clock edge.
  task automatic model_step(input logic tk, input bit v, input logic [3:0] a, input logic [31:0] d);
    logic [3:0] e, rs;
    logic [7:0] rq;
    logic [4:0] lp;
    e = '0; rs = '0; rq = '0;
    for (int i = 0; i < 4; i++)
      if (tk && m_cfg[i][20] && m_cnt[i] <= 1) e[i] = 1'b1;
    for (int i = 0; i < 4; i++)
      if (e[i]) begin rq |= m_cfg[i][31:24]; rs |= m_cfg[i][19:16]; end
    for (int i = 0; i < 4; i++) begin
      if (v && a[1:0] == 2'(i) && a[3:2] != 2'd3) begin
        case (a[3:2])
          2'd0: m_cfg[i] = d & WMASK;
          2'd1: m_cfg[i] = m_cfg[i] | (d & WMASK);
          default: m_cfg[i] = m_cfg[i] & ~d;
        endcase
        if (a[3:2] != 2'd2 && d[20]) m_cnt[i] = int'(m_cfg[i][10:0]);
      end else begin
        if (e[i]) begin
          lp = m_cfg[i][15:11];
          if (lp != 0) lp = lp - 1;
          m_cfg[i][15:11] = lp;
          m_cnt[i] = int'(m_cfg[i][10:0]);
          if (lp == 0) m_cfg[i][20] = 1'b0;
        end else if (tk && m_cfg[i][20]) m_cnt[i] = m_cnt[i] - 1;
        if (rs[i]) begin m_cfg[i][20] = 1'b1; m_cnt[i] = int'(m_cfg[i][10:0]); end
      end
    end
    exp_req = rq;
    exp_exp = e;
  endtask

  task automatic cycle(input bit v, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc++;
    obs_req = conv_req;
    obs_exp = dly_expire;
    chk(obs_req == exp_req, "R5", "conv_req vs model", 32'(obs_req), 32'(exp_req));
    chk(obs_exp == exp_exp, "R4", "dly_expire vs model", 32'(obs_exp), 32'(exp_exp));
    rd_addr = 2'(rd_sel);
    rd_sel = (rd_sel + 1) % 4;
    #1;
    chk(rd_data == m_cfg[rd_addr], "R7 R9", "register readback vs model", rd_data, m_cfg[rd_addr]);
    wr_valid = v; wr_addr = a; wr_data = d;
    cur_tick = base_tick;
    if (cur_tick) begin
      if (seen_tick) chk(gap == DIV, "R2", "tick spacing", 32'(gap), 32'(DIV));
      seen_tick = 1; gap = 1;
    end else gap++;
    model_step(cur_tick, v, a, d);
  endtask

  task automatic wr(input int ch, input int op, input logic [31:0] d);
    cycle(1'b1, {2'(op), 2'(ch)}, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(1'b0, 4'h0, 32'h0);
  endtask

  task automatic peek(input int ch, output logic [31:0] val);
    rd_addr = 2'(ch);
    #0.2;
    val = rd_data;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) wr(i, 0, 32'h0);
    idle(4);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int ticks, n, last, bad;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_valid = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    for (int i = 0; i < 4; i++) begin m_cfg[i] = '0; m_cnt[i] = 0; end
    exp_req = '0; exp_exp = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      peek(i, rv);
      chk(rv == 32'h0, "R1", "register after reset", rv, 32'h0);
    end
    chk(conv_req == 8'h0 && dly_expire == 4'h0, "R1", "outputs after reset",
        {20'h0, dly_expire, conv_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_tick = base_tick;
    model_step(cur_tick, 1'b0, 4'h0, 32'h0);

    // R3: field layout, reserved bits read zero.
    wr(1, 0, mk(8'hA5, 0, 4'h0, 5'h13, 11'h2AB) | 32'h00E0_0000);
    idle(1);
    peek(1, rv);
    chk(rv == mk(8'hA5, 0, 0, 5'h13, 11'h2AB), "R3", "stored word", rv, mk(8'hA5, 0, 0, 5'h13, 11'h2AB));
    wr(1, 0, 32'h0);

    // R10: the fourth alias is ignored.
    wr(2, 3, 32'hFFFF_FFFF);
    idle(1);
    peek(2, rv);
    chk(rv == 32'h0, "R10", "register after ignored alias", rv, 32'h0);

    // R4: one-shot timing in ticks, for delay 5 and delay 0.
    for (int t = 0; t < 2; t++) begin
      int dl;
      dl = (t == 0) ? 5 : 0;
      wr(0, 0, mk(1, 1, 0, 0, dl));
      ticks = 0; n = 0;
      while (n < 200) begin
        cycle(1'b0, 4'h0, 32'h0);
        n++;
        if (obs_exp[0]) break;
        if (cur_tick) ticks++;
      end
      chk(ticks == ((dl == 0) ? 1 : dl), "R4", "ticks to expiry", 32'(ticks), 32'((dl == 0) ? 1 : dl));
      chk(obs_req == 8'h01, "R5", "slot request on expiry", 32'(obs_req), 32'h01);
      idle(1);
      chk(obs_exp[0] == 1'b0, "R5", "expiry pulse width", 32'(obs_exp), 32'h0);
      peek(0, rv);
      chk(rv[20] == 1'b0, "R7", "single shot clears run bit", 32'(rv[20]), 32'h0);
    end
    clear_all();

    // R6 and R5: channel 0 restarts channels 2 and 3 together.
    wr(2, 0, mk(8'h04, 0, 0, 0, 3));
    wr(3, 0, mk(8'h30, 0, 0, 0, 3));
    wr(0, 0, mk(8'h01, 1, 4'b1100, 0, 2));
    n = 0;
    do begin cycle(1'b0, 4'h0, 32'h0); n++; end while (!obs_exp[0] && n < 100);
    peek(2, rv);
    chk(rv[20] == 1'b1, "R6", "chain arms channel 2", 32'(rv[20]), 32'h1);
    peek(3, rv);
    chk(rv[20] == 1'b1, "R6", "chain arms channel 3", 32'(rv[20]), 32'h1);
    n = 0;
    do begin cycle(1'b0, 4'h0, 32'h0); n++; end while (!obs_exp[2] && n < 100);
    chk(obs_exp[3] == 1'b1, "R6", "chained channels expire together", 32'(obs_exp), 32'hC);
    chk(obs_req == 8'h34, "R5", "merged slot requests", 32'(obs_req), 32'h34);
    clear_all();

    // R11: 200-tick delay, five rounds.
    wr(0, 0, mk(8'h01, 1, 0, 5, 200));
    n = 0; last = -1; bad = 0;
    for (int k = 0; k < 200 * 5 * DIV + 300; k++) begin
      cycle(1'b0, 4'h0, 32'h0);
      if (obs_exp[0]) begin
        if (last >= 0 && (k - last) != 200 * DIV) bad++;
        last = k; n++;
      end
    end
    chk(n == 5, "R11", "rounds in batch", 32'(n), 32'd5);
    chk(bad == 0, "R11", "round spacing errors", 32'(bad), 32'h0);
    peek(0, rv);
    chk(rv[20] == 1'b0 && rv[15:11] == 5'd0, "R11", "run bit and rounds after batch",
        {rv[20], 11'h0, rv[15:11]}, 32'h0);
    clear_all();

    // R6 self chain keeps running; R8 stop by clear alias and zero write.
    wr(1, 0, mk(8'h02, 1, 4'b0010, 0, 4));
    n = 0;
    for (int k = 0; k < 200; k++) begin cycle(1'b0, 4'h0, 32'h0); if (obs_exp[1]) n++; end
    chk(n >= 15, "R6", "self-chained expiries", 32'(n), 32'd16);
    peek(1, rv);
    chk(rv[20] == 1'b1, "R6", "self chain stays armed", 32'(rv[20]), 32'h1);
    wr(1, 2, 32'h0010_0000);
    idle(1);
    n = 0;
    for (int k = 0; k < 60; k++) begin cycle(1'b0, 4'h0, 32'h0); if (obs_exp[1]) n++; end
    chk(n == 0, "R8", "expiries after clear", 32'(n), 32'h0);
    wr(1, 1, 32'h0010_0000);
    wr(1, 0, 32'h0);
    idle(1);
    n = 0;
    for (int k = 0; k < 60; k++) begin cycle(1'b0, 4'h0, 32'h0); if (obs_exp[1]) n++; end
    chk(n == 0, "R8", "expiries after zero write", 32'(n), 32'h0);
    peek(1, rv);
    chk(rv == 32'h0, "R8", "register after zero write", rv, 32'h0);
    clear_all();

    // R9: a write landing on the expiring tick keeps the channel armed.
    n = 0;
    do begin cycle(1'b0, 4'h0, 32'h0); n++; end while (!cur_tick && n < 20);
    wr(0, 0, mk(8'h01, 1, 0, 0, 2));
    idle(4);
    wr(0, 2, 32'h0100_0000);
    idle(1);
    chk(obs_exp[0] == 1'b1, "R9", "expiry still reported", 32'(obs_exp), 32'h1);
    peek(0, rv);
    chk(rv[20] == 1'b1 && rv[31:24] == 8'h00, "R9", "write wins over self-clear",
        {rv[31:24], 3'b0, rv[20], 20'h0}, 32'h0010_0000);
    clear_all();

    // Random traffic checked against the model (R3 to R10).
    for (int k = 0; k < 20000; k++) begin
      if (($urandom % 100) < 6) begin
        int ch, opr, op;
        logic [31:0] d;
        ch  = int'($urandom % 4);
        opr = int'($urandom % 8);
        op  = (opr < 4) ? 0 : (opr < 6) ? 1 : (opr == 6) ? 2 : 3;
        if (op == 2) d = $urandom;
        else d = mk(int'($urandom % 256), int'($urandom % 2),
                    (($urandom % 4) == 0) ? int'($urandom % 16) : 0,
                    int'($urandom % 4), int'($urandom % 7));
        wr(ch, op, d);
      end else cycle(1'b0, 4'h0, 32'h0);
    end
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule